// File: doc/BRIEF.md
# Shared Interrupt Source Router

This block collects a parameterised number of level-sensitive interrupt sources and steers each one to a single processor context and a single output line of that context. Every source has its own pending flag, enable flag, line selection and context selection. Software reaches all of this state through a word-wide register port. Reads are combinational. Writes take effect at the clock edge.

For every (context, line) pair the block drives an output that is high while at least one source meets four conditions: it is pending, it is enabled, it is steered to that context, and it is steered to that line. Enables change only through write-one-to-set and write-one-to-clear words. Software can also force a source's pending flag high or low through an injection register.

The source count must be a nonzero multiple of 8 and no more than 256. Register word addresses are used throughout; each entry is one 32-bit word.

Top module: `irq_source_router`

## Requirements
- R1: After reset all pending and enable flags are 0 and every output is 0. Every line-selection word reads 0x8000_0000 and every context-selection word reads 0.
- R2: A source's pending flag takes the new input level in the cycle in which that input changes, even while the source is disabled. Pending status words at 0x000+w pack source 32w+b into bit b.
- R3: Output bit v*NUM_PIN+p is the OR of (pending AND enabled) over the sources steered to context v and line p. It changes in the cycle after the pending or enable state changes.
- R4: A write to 0x020+w sets the enable of source 32w+b for every 1 in data bit b. A write to 0x030+w clears those enables. Zero bits leave enables unchanged. Enable status reads at 0x010+w with the same packing.
- R5: A write to context-selection word 0x200+s picks the index of the lowest set data bit. Writing zero leaves the source unsteered. A write whose index is not below NUM_VP is ignored.
- R6: A context-selection word reads back as a one-hot word with the selected context's bit set, or 0 when the source is unsteered.
- R7: A write to line-selection word 0x100+s keeps only data bit 31 (the steer flag) and bits 5:0 (the line number). The write is ignored when the line number exceeds NUM_PIN-1.
- R8: A write to the injection word 0x040 sets the pending flag of the source indexed by data bits 7:0 to data bit 31. Indices at or above NUM_SRC are ignored. An injection overrides an input change for that source in the same cycle.
- R9: Status and mask words beyond the last source word, and selection words of sources at or above NUM_SRC, read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcLevel | input | NUM_SRC | Source interrupt levels |
| busWe | input | 1 | Register write strobe |
| busAddr | input | 12 | Register word address |
| busWdata | input | 32 | Register write data |
| busRdata | output | 32 | Register read data (combinational) |
| ctxIrq | output | NUM_VP*NUM_PIN | Per context and line interrupt outputs |

## Verification
The bench targets the decode edges. An out-of-range context index must not change the steering; a design that wrapped it would move the source to another context. A line number above the limit must not change the line selection. A source or word index past the source count must not alias onto a real source; an aliasing design would corrupt another source's state. The bench checks that a disabled source still records its input level, so re-enabling that source raises its output at once. A design that gated capture with the enable would keep the output low. The bench drives an input change and an injection in the same cycle and checks that the injection wins; a design with the opposite priority would leave the source pending.

// File: rtl/irq_router_pkg.sv
`timescale 1ns/1ps
package irq_router_pkg;
  localparam int ADDR_W  = 12;
  localparam int IDX_W   = 8;
  localparam int VPIDX_W = 5;
  localparam int PIN_W   = 6;

  localparam logic [7:0]  REG_PEND   = 8'h00;
  localparam logic [7:0]  REG_MASK   = 8'h01;
  localparam logic [7:0]  REG_SET    = 8'h02;
  localparam logic [7:0]  REG_CLR    = 8'h03;
  localparam logic [11:0] REG_WEDGE  = 12'h040;
  localparam logic [3:0]  REG_PINMAP = 4'h1;
  localparam logic [3:0]  REG_VPMAP  = 4'h2;

  typedef enum logic [2:0] {RD_NONE, RD_PEND, RD_MASK, RD_PIN, RD_VP} rdSel_e;

  typedef struct packed {
    logic               setMask;
    logic               clrMask;
    logic               wedgeWr;
    logic               wedgeLvl;
    logic               pinWr;
    logic               pinFlag;
    logic [PIN_W-1:0]   pinNum;
    logic               vpWr;
    logic               vpValid;
    logic [VPIDX_W-1:0] vpIdx;
    logic [IDX_W-1:0]   srcIdx;
    logic [2:0]         wordIdx;
    logic [31:0]        bits;
    rdSel_e             rdSel;
  } ctrlStb_t;
endpackage

// File: rtl/irq_router_ctrl.sv
`timescale 1ns/1ps
module irq_router_ctrl
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int NUM_VP  = 4,
  parameter int NUM_PIN = 6
) (
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output ctrlStb_t          stb
);
  localparam int NUM_WORDS = (NUM_SRC + 31) / 32;

  function automatic logic [VPIDX_W-1:0] lowestSet(input logic [31:0] d);
    lowestSet = '0;
    for (int i = 31; i >= 0; i--) begin
      if (d[i]) lowestSet = VPIDX_W'(i);
    end
  endfunction

  logic [VPIDX_W-1:0] lowIdx;
  logic wordOk, srcOk, pinOk, vpOk, wedgeOk;
  logic inPend, inMask, inSet, inClr, inWedge, inPin, inVp;

  assign lowIdx  = lowestSet(busWdata);
  assign wordOk  = int'(busAddr[3:0]) < NUM_WORDS;
  assign srcOk   = int'(busAddr[7:0]) < NUM_SRC;
  assign pinOk   = int'(busWdata[PIN_W-1:0]) < NUM_PIN;
  assign vpOk    = (busWdata == '0) || (int'(lowIdx) < NUM_VP);
  assign wedgeOk = int'(busWdata[IDX_W-1:0]) < NUM_SRC;

  assign inPend  = (busAddr[ADDR_W-1:4] == REG_PEND) && wordOk;
  assign inMask  = (busAddr[ADDR_W-1:4] == REG_MASK) && wordOk;
  assign inSet   = (busAddr[ADDR_W-1:4] == REG_SET) && wordOk;
  assign inClr   = (busAddr[ADDR_W-1:4] == REG_CLR) && wordOk;
  assign inWedge = (busAddr == REG_WEDGE);
  assign inPin   = (busAddr[ADDR_W-1:8] == REG_PINMAP) && srcOk;
  assign inVp    = (busAddr[ADDR_W-1:8] == REG_VPMAP) && srcOk;

  always_comb begin
    stb          = '0;
    stb.bits     = busWdata;
    stb.wordIdx  = busAddr[2:0];
    stb.srcIdx   = inWedge ? busWdata[IDX_W-1:0] : busAddr[IDX_W-1:0];
    stb.setMask  = busWe && inSet;
    stb.clrMask  = busWe && inClr;
    stb.wedgeWr  = busWe && inWedge && wedgeOk;
    stb.wedgeLvl = busWdata[31];
    stb.pinWr    = busWe && inPin && pinOk;
    stb.pinFlag  = busWdata[31];
    stb.pinNum   = busWdata[PIN_W-1:0];
    stb.vpWr     = busWe && inVp && vpOk;
    stb.vpValid  = (busWdata != '0);
    stb.vpIdx    = lowIdx;
    if (inPend)      stb.rdSel = RD_PEND;
    else if (inMask) stb.rdSel = RD_MASK;
    else if (inPin)  stb.rdSel = RD_PIN;
    else if (inVp)   stb.rdSel = RD_VP;
    else             stb.rdSel = RD_NONE;
  end
endmodule

// File: rtl/irq_router_dp.sv
`timescale 1ns/1ps
module irq_router_dp
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [NUM_SRC-1:0]                srcLevel,
  input  ctrlStb_t                          stb,
  output logic [31:0]                       rdData,
  output logic [NUM_SRC-1:0]                pendVec,
  output logic [NUM_SRC-1:0]                enVec,
  output logic [NUM_SRC-1:0][PIN_W-1:0]     pinNumVec,
  output logic [NUM_SRC-1:0]                vpOnVec,
  output logic [NUM_SRC-1:0][VPIDX_W-1:0]   vpNumVec
);
  localparam int NUM_WORDS = (NUM_SRC + 31) / 32;

  logic [NUM_SRC-1:0] pinFlagVec;
  logic [NUM_WORDS*32-1:0] pendPad, enPad;
  logic [NUM_WORDS-1:0][31:0] pendWords, enWords;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    localparam int WRD = s / 32;
    localparam int BIT = s % 32;
    logic hitIdx, hitWord;
    logic lastQ, pendQ, enQ, flagQ, vpOnQ;
    logic [PIN_W-1:0] pinQ;
    logic [VPIDX_W-1:0] vpQ;

    assign hitIdx  = (stb.srcIdx == IDX_W'(s));
    assign hitWord = (stb.wordIdx == 3'(WRD)) && stb.bits[BIT];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        lastQ <= 1'b0;
        pendQ <= 1'b0;
        enQ   <= 1'b0;
        flagQ <= 1'b1;
        pinQ  <= '0;
        vpOnQ <= 1'b0;
        vpQ   <= '0;
      end else begin
        lastQ <= srcLevel[s];
        if (stb.wedgeWr && hitIdx)      pendQ <= stb.wedgeLvl;
        else if (srcLevel[s] != lastQ)  pendQ <= srcLevel[s];
        if (stb.setMask && hitWord)      enQ <= 1'b1;
        else if (stb.clrMask && hitWord) enQ <= 1'b0;
        if (stb.pinWr && hitIdx) begin
          flagQ <= stb.pinFlag;
          pinQ  <= stb.pinNum;
        end
        if (stb.vpWr && hitIdx) begin
          vpOnQ <= stb.vpValid;
          vpQ   <= stb.vpIdx;
        end
      end
    end

    assign pendVec[s]    = pendQ;
    assign enVec[s]      = enQ;
    assign pinFlagVec[s] = flagQ;
    assign pinNumVec[s]  = pinQ;
    assign vpOnVec[s]    = vpOnQ;
    assign vpNumVec[s]   = vpQ;
  end

  assign pendPad   = (NUM_WORDS*32)'(pendVec);
  assign enPad     = (NUM_WORDS*32)'(enVec);
  assign pendWords = pendPad;
  assign enWords   = enPad;

  always_comb begin
    rdData = '0;
    case (stb.rdSel)
      RD_PEND: for (int w = 0; w < NUM_WORDS; w++)
                 if (stb.wordIdx == 3'(w)) rdData = pendWords[w];
      RD_MASK: for (int w = 0; w < NUM_WORDS; w++)
                 if (stb.wordIdx == 3'(w)) rdData = enWords[w];
      RD_PIN:  for (int s = 0; s < NUM_SRC; s++)
                 if (stb.srcIdx == IDX_W'(s))
                   rdData = {pinFlagVec[s], {(31-PIN_W){1'b0}}, pinNumVec[s]};
      RD_VP:   for (int s = 0; s < NUM_SRC; s++)
                 if (stb.srcIdx == IDX_W'(s))
                   rdData = vpOnVec[s] ? (32'd1 << vpNumVec[s]) : 32'd0;
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/irq_router_net.sv
`timescale 1ns/1ps
module irq_router_net
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int NUM_VP  = 4,
  parameter int NUM_PIN = 6
) (
  input  logic [NUM_SRC-1:0]              pendVec,
  input  logic [NUM_SRC-1:0]              enVec,
  input  logic [NUM_SRC-1:0][PIN_W-1:0]   pinNumVec,
  input  logic [NUM_SRC-1:0]              vpOnVec,
  input  logic [NUM_SRC-1:0][VPIDX_W-1:0] vpNumVec,
  output logic [NUM_VP*NUM_PIN-1:0]       ctxIrq
);
  logic [NUM_SRC-1:0] live;
  assign live = pendVec & enVec & vpOnVec;

  for (genvar v = 0; v < NUM_VP; v++) begin : g_vp
    for (genvar p = 0; p < NUM_PIN; p++) begin : g_pin
      logic [NUM_SRC-1:0] hits;
      for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        assign hits[s] = live[s] && (vpNumVec[s] == VPIDX_W'(v)) &&
                         (pinNumVec[s] == PIN_W'(p));
      end
      assign ctxIrq[v*NUM_PIN + p] = |hits;
    end
  end
endmodule

// File: rtl/irq_source_router.sv
`timescale 1ns/1ps
module irq_source_router
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int NUM_VP  = 4,
  parameter int NUM_PIN = 6
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_SRC-1:0]        srcLevel,
  input  logic                      busWe,
  input  logic [ADDR_W-1:0]         busAddr,
  input  logic [31:0]               busWdata,
  output logic [31:0]               busRdata,
  output logic [NUM_VP*NUM_PIN-1:0] ctxIrq
);
  ctrlStb_t stb;
  logic [NUM_SRC-1:0] pendVec, enVec, vpOnVec;
  logic [NUM_SRC-1:0][PIN_W-1:0] pinNumVec;
  logic [NUM_SRC-1:0][VPIDX_W-1:0] vpNumVec;

  irq_router_ctrl #(.NUM_SRC(NUM_SRC), .NUM_VP(NUM_VP), .NUM_PIN(NUM_PIN)) u_ctrl (
    .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata), .stb(stb)
  );

  irq_router_dp #(.NUM_SRC(NUM_SRC)) u_dp (
    .clk(clk), .rstN(rstN), .srcLevel(srcLevel), .stb(stb), .rdData(busRdata),
    .pendVec(pendVec), .enVec(enVec), .pinNumVec(pinNumVec),
    .vpOnVec(vpOnVec), .vpNumVec(vpNumVec)
  );

  irq_router_net #(.NUM_SRC(NUM_SRC), .NUM_VP(NUM_VP), .NUM_PIN(NUM_PIN)) u_net (
    .pendVec(pendVec), .enVec(enVec), .pinNumVec(pinNumVec),
    .vpOnVec(vpOnVec), .vpNumVec(vpNumVec), .ctxIrq(ctxIrq)
  );
endmodule

// File: rtl/irq_router_chk.sv
`timescale 1ns/1ps
module irq_router_chk
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int NUM_VP  = 4,
  parameter int NUM_PIN = 6
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      busWe,
  input logic [ADDR_W-1:0]         busAddr,
  input logic [31:0]               busWdata,
  input logic [31:0]               busRdata,
  input logic [NUM_VP*NUM_PIN-1:0] ctxIrq,
  input logic [NUM_SRC-1:0]        pendVec,
  input logic [NUM_SRC-1:0]        enVec
);
  localparam int NUM_WORDS = (NUM_SRC + 31) / 32;
  localparam logic [31:0] W0MASK = (NUM_SRC >= 32) ? 32'hFFFF_FFFF : ((32'd1 << NUM_SRC) - 32'd1);

  logic [NUM_WORDS*32-1:0] enPad;
  logic [31:0] en0;
  assign enPad = (NUM_WORDS*32)'(enVec);
  assign en0   = enPad[31:0];

  AST_IRQ_NEEDS_LIVE: assert property (@(posedge clk) disable iff (!rstN)
    (ctxIrq != '0) |-> ((pendVec & enVec) != '0)); // R3

  AST_SETMASK_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == {REG_SET, 4'h0}) |=>
      ((en0 & $past(busWdata) & W0MASK) == ($past(busWdata) & W0MASK))); // R4

  AST_CLRMASK_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == {REG_CLR, 4'h0}) |=> ((en0 & $past(busWdata)) == 32'd0)); // R4

  AST_VPMAP_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr[ADDR_W-1:8] == REG_VPMAP) |-> $onehot0(busRdata)); // R6

  AST_WEDGE_SRC0: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == REG_WEDGE && busWdata[IDX_W-1:0] == '0) |=>
      (pendVec[0] == $past(busWdata[31]))); // R8
endmodule

bind irq_source_router irq_router_chk #(.NUM_SRC(NUM_SRC), .NUM_VP(NUM_VP), .NUM_PIN(NUM_PIN)) u_chk (
  .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
  .busRdata(busRdata), .ctxIrq(ctxIrq), .pendVec(pendVec), .enVec(enVec)
);

// File: tb/sim_irq_source_router.sv
`timescale 1ns/1ps
module sim_irq_source_router;
  localparam int NS = 64;
  localparam int NV = 4;
  localparam int NP = 6;
  localparam int NVEC = 37;

  logic clk = 1'b0;
  logic rstN;
  logic [NS-1:0] srcLevel;
  logic busWe;
  logic [11:0] busAddr;
  logic [31:0] busWdata;
  logic [31:0] busRdata;
  logic [NV*NP-1:0] ctxIrq;
  int nChk = 0;
  int nBad = 0;

  always #5 clk = ~clk;

  irq_source_router #(.NUM_SRC(NS), .NUM_VP(NV), .NUM_PIN(NP)) u0 (
    .clk(clk), .rstN(rstN), .srcLevel(srcLevel), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .ctxIrq(ctxIrq)
  );

  // {op(1=read check), addr(12), data(32), expected(32), requirement(4)}
  localparam logic [80:0] VEC [NVEC] = '{
    {1'b1, 12'h105, 32'h0, 32'h8000_0000, 4'd1},   // R1 line selection reset value
    {1'b1, 12'h205, 32'h0, 32'h0,         4'd1},   // R1 context selection reset value
    {1'b1, 12'h010, 32'h0, 32'h0,         4'd1},   // R1 enables clear
    {1'b1, 12'h000, 32'h0, 32'h0,         4'd1},   // R1 pending clear
    {1'b0, 12'h020, 32'h0000_00F0, 32'h0, 4'd4},
    {1'b1, 12'h010, 32'h0, 32'h0000_00F0, 4'd4},   // R4 set
    {1'b0, 12'h030, 32'h0000_0030, 32'h0, 4'd4},
    {1'b1, 12'h010, 32'h0, 32'h0000_00C0, 4'd4},   // R4 clear
    {1'b0, 12'h021, 32'h8000_0001, 32'h0, 4'd4},
    {1'b1, 12'h011, 32'h0, 32'h8000_0001, 4'd4},   // R4 second word
    {1'b1, 12'h010, 32'h0, 32'h0000_00C0, 4'd4},   // R4 first word untouched
    {1'b0, 12'h206, 32'h0000_000C, 32'h0, 4'd5},
    {1'b1, 12'h206, 32'h0, 32'h0000_0004, 4'd5},   // R5 lowest set bit
    {1'b0, 12'h206, 32'h0000_0010, 32'h0, 4'd5},
    {1'b1, 12'h206, 32'h0, 32'h0000_0004, 4'd5},   // R5 index 4 ignored
    {1'b0, 12'h206, 32'h0, 32'h0,         4'd5},
    {1'b1, 12'h206, 32'h0, 32'h0,         4'd6},   // R6 unsteered reads zero
    {1'b0, 12'h106, 32'hFFFF_FFC3, 32'h0, 4'd7},
    {1'b1, 12'h106, 32'h0, 32'h8000_0003, 4'd7},   // R7 field masking
    {1'b0, 12'h106, 32'h0000_0006, 32'h0, 4'd7},
    {1'b1, 12'h106, 32'h0, 32'h8000_0003, 4'd7},   // R7 line 6 ignored
    {1'b0, 12'h022, 32'hFFFF_FFFF, 32'h0, 4'd9},
    {1'b1, 12'h012, 32'h0, 32'h0,         4'd9},   // R9 word beyond count
    {1'b1, 12'h010, 32'h0, 32'h0000_00C0, 4'd9},   // R9 no alias
    {1'b0, 12'h146, 32'h0000_0003, 32'h0, 4'd9},
    {1'b1, 12'h146, 32'h0, 32'h0,         4'd9},   // R9 source 70
    {1'b0, 12'h040, 32'h8000_0007, 32'h0, 4'd8},
    {1'b1, 12'h000, 32'h0, 32'h0000_0080, 4'd8},   // R8 inject high
    {1'b0, 12'h040, 32'h8000_0050, 32'h0, 4'd8},
    {1'b1, 12'h001, 32'h0, 32'h0,         4'd8},   // R8 index 80 ignored
    {1'b1, 12'h000, 32'h0, 32'h0000_0080, 4'd8},   // R8 no alias
    {1'b0, 12'h040, 32'h0000_0007, 32'h0, 4'd8},
    {1'b1, 12'h000, 32'h0, 32'h0,         4'd8},   // R8 inject low
    {1'b0, 12'h207, 32'h8000_0000, 32'h0, 4'd5},
    {1'b1, 12'h207, 32'h0, 32'h0,         4'd5},   // R5 index 31 ignored
    {1'b0, 12'h207, 32'h0000_0008, 32'h0, 4'd6},
    {1'b1, 12'h207, 32'h0, 32'h0000_0008, 4'd6}    // R6 one-hot context 3
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    busAddr = a;
    #1;
    chk(tag, busRdata, exp);
  endtask

  initial begin
    #(200000 * 10);
    nBad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

  initial begin
    rstN = 1'b0; srcLevel = '0; busWe = 1'b0; busAddr = '0; busWdata = '0;
    repeat (3) @(negedge clk);
    chk("R1 outputs in reset", 32'(ctxIrq), 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][80]) rd(VEC[i][79:68], VEC[i][35:4], $sformatf("R%0d vec%0d", VEC[i][3:0], i));
      else            wr(VEC[i][79:68], VEC[i][67:36]);
    end

    // R2: a disabled source still records its level; R3: no output for it
    @(negedge clk); srcLevel[3] = 1'b1;
    @(negedge clk);
    rd(12'h000, 32'h0000_0008, "R2 disabled source pending");
    chk("R3 disabled source silent", 32'(ctxIrq), 32'h0);

    // R3: steer source 6 (line 3, enabled) to context 1
    wr(12'h206, 32'h0000_0002);
    srcLevel[6] = 1'b1;
    @(negedge clk);
    chk("R3 route ctx1 line3", 32'(ctxIrq), 32'h1 << (1*NP + 3));
    wr(12'h030, 32'h0000_0040);
    chk("R3 drop after disable", 32'(ctxIrq), 32'h0);
    rd(12'h000, 32'h0000_0048, "R2 pending kept while disabled");
    wr(12'h020, 32'h0000_0040);
    chk("R3 rise after enable", 32'(ctxIrq), 32'h1 << (1*NP + 3));
    srcLevel[6] = 1'b0;
    @(negedge clk);
    chk("R3 drop on level low", 32'(ctxIrq), 32'h0);
    rd(12'h000, 32'h0000_0008, "R2 pending follows low");

    // R8: injection beats an input change in the same cycle
    srcLevel[9] = 1'b1;
    wr(12'h040, 32'h0000_0009);
    rd(12'h000, 32'h0000_0008, "R8 injection priority");
    @(negedge clk);
    rd(12'h000, 32'h0000_0008, "R2 steady level no recapture");
    wr(12'h040, 32'h8000_0006);
    chk("R8 injection drives output", 32'(ctxIrq), 32'h1 << (1*NP + 3));

    // R1: reset mid-run restores defaults
    rstN = 1'b0;
    #1;
    chk("R1 outputs after reset", 32'(ctxIrq), 32'h0);
    rd(12'h010, 32'h0, "R1 enables after reset");
    rd(12'h106, 32'h8000_0000, "R1 line selection after reset");
    rd(12'h206, 32'h0, "R1 context selection after reset");

    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end
endmodule